// File: doc/BRIEF.md
# Memory Training Pattern Generator and Checker

This block produces the write data used while a memory interface is being trained, and checks the data read back against a second copy of the same stream. Each beat carries one bit of a serial training stream on every lane. When the inversion option is set, odd-numbered lanes carry the complement, so that each lane is always driven against its neighbours. Firmware chooses one of three stream kinds through `cfg_mode`:
- a plain toggle, which is the simple alternating pattern a DRAM can return on its own;
- a 7-bit pseudo-random sequence with a programmable seed;
- a sweep whose run lengths grow from single bits to long runs of 0s and 1s.

The PRBS and sweep streams both contain long constant runs, so they carry high, middle and low frequency content and stress intersymbol interference. A single toggle frequency does not.

A one-cycle `start` pulse latches the mode and seed into the transmit and the receive generator, and clears the error state. The block then issues one beat per cycle until `stop` is pulsed. The read path holds its own generator, which advances only on beats marked with `rd_valid`. Every lane that disagrees sets a sticky flag, and the number of disagreeing bits is added to a saturating counter. Choosing sampling delays or reference voltages is left to the logic around it.

Top module: `tpg_train_pattern`

## Requirements
- R1: After reset, `running`, `wr_valid`, `wr_data`, `err_flags` and `err_count` are all zero.
- R2: A `start` pulse captures `cfg_mode` and `cfg_seed`. From the next cycle on, `wr_valid` is high and one new beat appears on `wr_data` every cycle, until a `stop` pulse makes `wr_valid` and `wr_data` zero in the cycle after it. When `start` and `stop` are high together, `start` wins.
- R3: Mode code 0 gives a toggle stream whose base bit is 0 on the first beat after start and alternates on every beat after that. Code 3 behaves the same as code 0.
- R4: Mode code 1 gives a PRBS stream from a 7-bit register loaded with the seed. A seed of zero is loaded as 1. The base bit of each beat is register bit 6. The register then shifts toward bit 6, and bit 6 XOR bit 5 enters at bit 0 (polynomial x^7+x^6+1).
- R5: Mode code 2 gives a sweep stream. For each run length in the order 1, 2, 4, 8, 16 and 32, it emits that many 0 bits followed by that many 1 bits. After 126 beats it starts again at length 1.
- R6: Lane i of the output carries the base bit. When INVERT_ODD is 1 (the default), each odd lane carries the complement of the base bit.
- R7: Each `rd_valid` beat taken while running is compared lane by lane with the regenerated stream. Lane i of `err_flags` is set in the next cycle when lane i disagrees. It stays set until the next start or reset.
- R8: `err_count` grows by the number of disagreeing lanes of each compared beat and saturates at 65535.
- R9: `rd_valid` has no effect on `err_flags` or `err_count` while the block is not running.
- R10: A `start` pulse clears `err_flags` and `err_count` in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Stream kind: 0 toggle, 1 PRBS, 2 sweep, 3 toggle |
| cfg_seed | input | 7 | PRBS seed, captured on start |
| start | input | 1 | One-cycle pulse that begins a run |
| stop | input | 1 | One-cycle pulse that ends a run |
| running | output | 1 | High while a run is active |
| wr_valid | output | 1 | Marks a beat on wr_data |
| wr_data | output | LANES | Training write beat |
| rd_valid | input | 1 | Marks a read-back beat on rd_data |
| rd_data | input | LANES | Read-back beat to be checked |
| err_flags | output | LANES | Sticky mismatch flag for each lane |
| err_count | output | ERR_W | Saturating count of mismatching bits |

## Verification
Assertions check several rules on every cycle:
- the error flags only gain bits, and the counter never moves down, between starts;
- neither changes while the block is idle;
- a start clears both, and a stop silences the write port;
- the PRBS register never holds zero, and the sweep run counter stays inside its current run.

The exact content of each stream can only be shown by the bench's scenarios. Those scenarios cover the toggle phase, the PRBS sequence for a chosen seed and for the zero seed, the full sweep period with its wrap, and odd-lane inversion. The same goes for the lane and cycle at which an injected error shows up, and for the counter holding at 65535 after a long run of bad beats.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
   typedef enum logic [1:0] {
      PAT_TOGGLE  = 2'd0,
      PAT_PRBS    = 2'd1,
      PAT_SWEEP   = 2'd2,
      PAT_TOGGLE2 = 2'd3
   } pat_mode_e;

   localparam int PRBS_W = 7;

   // one step of the x^7+x^6+1 register, output taken from the top bit
   function automatic logic [PRBS_W-1:0] prbs_next(input logic [PRBS_W-1:0] s);
      return {s[PRBS_W-2:0], s[PRBS_W-1] ^ s[PRBS_W-2]};
   endfunction
endpackage

// File: rtl/tpg_stream.sv
module tpg_stream
   import tpg_pkg::*;
#(
   parameter int SWEEP_STEPS = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   input  logic [1:0]        mode_i,
   input  logic [PRBS_W-1:0] seed_i,
   output logic              bit_o
);
   localparam int IDX_W = (SWEEP_STEPS > 1) ? $clog2(SWEEP_STEPS) : 1;
   localparam int CNT_W = SWEEP_STEPS;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SWEEP_STEPS - 1);

   pat_mode_e          mode_q;
   logic               tog_q;
   logic [PRBS_W-1:0]  lfsr_q;
   logic [IDX_W-1:0]   idx_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               pol_q;
   logic [CNT_W-1:0]   run_len;
   logic               run_end;

   assign run_len = CNT_W'(1) << idx_q;
   assign run_end = (cnt_q == run_len - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= PAT_TOGGLE;
         tog_q  <= 1'b0;
         lfsr_q <= PRBS_W'(1);
         idx_q  <= '0;
         cnt_q  <= '0;
         pol_q  <= 1'b0;
      end else if (load) begin
         mode_q <= pat_mode_e'(mode_i);
         tog_q  <= 1'b0;
         lfsr_q <= (seed_i == '0) ? PRBS_W'(1) : seed_i;
         idx_q  <= '0;
         cnt_q  <= '0;
         pol_q  <= 1'b0;
      end else if (advance) begin
         tog_q  <= ~tog_q;
         lfsr_q <= prbs_next(lfsr_q);
         if (run_end) begin
            cnt_q <= '0;
            pol_q <= ~pol_q;
            if (pol_q) idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + IDX_W'(1);
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   always_comb begin
      case (mode_q)
         PAT_PRBS:  bit_o = lfsr_q[PRBS_W-1];
         PAT_SWEEP: bit_o = pol_q;
         default:   bit_o = tog_q;
      endcase
   end

   a_r4_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);
   a_r5_run_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < run_len);
   a_r5_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= IDX_LAST);
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
   parameter int LANES = 8,
   parameter int ERR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             check_en,
   input  logic [LANES-1:0] rd_data,
   input  logic [LANES-1:0] exp_data,
   output logic [LANES-1:0] flags,
   output logic [ERR_W-1:0] count
);
   localparam int POP_W = $clog2(LANES + 1);
   localparam logic [ERR_W:0] CNT_MAX = {1'b0, {ERR_W{1'b1}}};

   logic [LANES-1:0] miss;
   logic [POP_W-1:0] pop;
   logic [ERR_W:0]   sum;

   assign miss = rd_data ^ exp_data;

   always_comb begin
      pop = '0;
      for (int i = 0; i < LANES; i++) pop = pop + POP_W'(miss[i]);
   end

   assign sum = {1'b0, count} + (ERR_W+1)'(pop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         count <= '0;
      end else if (clear) begin
         flags <= '0;
         count <= '0;
      end else if (check_en) begin
         flags <= flags | miss;
         count <= (sum > CNT_MAX) ? CNT_MAX[ERR_W-1:0] : sum[ERR_W-1:0];
      end
   end

   a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> ((flags & $past(flags)) == $past(flags)));
   a_r8_count_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (count >= $past(count)));
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !check_en) |=> ($stable(flags) && $stable(count)));
   a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (flags == '0 && count == '0));
endmodule

// File: rtl/tpg_train_pattern.sv
module tpg_train_pattern
   import tpg_pkg::*;
#(
   parameter int LANES       = 8,
   parameter int ERR_W       = 16,
   parameter int SWEEP_STEPS = 6,
   parameter bit INVERT_ODD  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_mode,
   input  logic [6:0]       cfg_seed,
   input  logic             start,
   input  logic             stop,
   output logic             running,
   output logic             wr_valid,
   output logic [LANES-1:0] wr_data,
   input  logic             rd_valid,
   input  logic [LANES-1:0] rd_data,
   output logic [LANES-1:0] err_flags,
   output logic [ERR_W-1:0] err_count
);
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (ERR_W < 2 || (ERR_W < 31 && LANES >= (1 << ERR_W))) begin : g_bad_errw
      $error("ERR_W too narrow for LANES");
   end
   if (SWEEP_STEPS < 1 || SWEEP_STEPS > 12) begin : g_bad_sweep
      $error("SWEEP_STEPS must lie in 1..12");
   end

   logic             run_q;
   logic             tx_bit, rx_bit;
   logic [LANES-1:0] tx_word, rx_word;
   logic             chk_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_q <= 1'b0;
      else if (start) run_q <= 1'b1;
      else if (stop)  run_q <= 1'b0;
   end

   assign chk_en = run_q && rd_valid && !start;

   tpg_stream #(.SWEEP_STEPS(SWEEP_STEPS)) u_tx (
      .clk(clk), .rst_n(rst_n), .load(start), .advance(run_q),
      .mode_i(cfg_mode), .seed_i(cfg_seed), .bit_o(tx_bit));

   tpg_stream #(.SWEEP_STEPS(SWEEP_STEPS)) u_rx (
      .clk(clk), .rst_n(rst_n), .load(start), .advance(chk_en),
      .mode_i(cfg_mode), .seed_i(cfg_seed), .bit_o(rx_bit));

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (INVERT_ODD && (i % 2 == 1)) begin : g_inv
         assign tx_word[i] = ~tx_bit;
         assign rx_word[i] = ~rx_bit;
      end else begin : g_pass
         assign tx_word[i] = tx_bit;
         assign rx_word[i] = rx_bit;
      end
   end

   tpg_checker #(.LANES(LANES), .ERR_W(ERR_W)) u_chk (
      .clk(clk), .rst_n(rst_n), .clear(start), .check_en(chk_en),
      .rd_data(rd_data), .exp_data(rx_word),
      .flags(err_flags), .count(err_count));

   assign running  = run_q;
   assign wr_valid = run_q;
   assign wr_data  = run_q ? tx_word : '0;

   a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> wr_valid);
   a_r2_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !start) |=> (!wr_valid && wr_data == '0));
endmodule

// File: tb/tpg_train_pattern_tb.sv
`timescale 1ns/1ps
module tpg_train_pattern_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_mode = 2'd0;
   logic [6:0] cfg_seed = 7'd0;
   logic       start = 1'b0, stop = 1'b0;
   logic       running, wr_valid, rd_valid = 1'b0;
   logic [7:0] wr_data, rd_data = 8'h00, err_flags;
   logic [15:0] err_count;

   int total = 0, bad = 0;
   bit wd_hit = 0;

   // reference state
   int m_mode, m_lfsr, m_n;
   bit sq[$];
   logic [7:0] m_flags;
   int m_count;

   always #2 clk = ~clk;

   tpg_train_pattern u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_seed(cfg_seed),
      .start(start), .stop(stop), .running(running), .wr_valid(wr_valid),
      .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
      .err_flags(err_flags), .err_count(err_count));

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic next_bit(output bit b);
      case (m_mode)
         1: begin
            b = m_lfsr[6];
            m_lfsr = ((m_lfsr << 1) & 8'h7f) | (((m_lfsr >> 6) ^ (m_lfsr >> 5)) & 1);
         end
         2: b = sq[m_n % sq.size()];
         default: b = m_n[0];
      endcase
      m_n++;
   endtask

   function automatic logic [7:0] lanes_of(input bit b);
      return b ? 8'h55 : 8'hAA;   // odd lanes inverted (R6)
   endfunction

   task automatic begin_run(input int mode, input int seed, input bit with_stop);
      @(negedge clk);
      cfg_mode = 2'(mode); cfg_seed = 7'(seed);
      start = 1'b1; stop = with_stop; rd_valid = 1'b0;
      @(negedge clk);
      start = 1'b0; stop = 1'b0;
      m_mode = (mode == 3) ? 0 : mode;
      m_lfsr = (seed == 0) ? 1 : seed;
      m_n = 0; m_flags = 8'h00; m_count = 0;
      chk(err_flags == 8'h00 && err_count == 0, "R10", "clear on start",
          {err_flags, err_count}, 0);
   endtask

   // runs nb beats; lanes in e_mask flipped on beat e_beat, or every beat if all_bad
   task automatic run_beats(input int nb, input string req, input int e_beat,
                            input logic [7:0] e_mask, input bit all_bad);
      for (int k = 0; k < nb; k++) begin
         bit b;
         logic [7:0] exp, inj;
         next_bit(b);
         exp = lanes_of(b);
         chk(wr_valid === 1'b1, "R2", "wr_valid", wr_valid, 1);
         chk(wr_data === exp, req, "wr_data", wr_data, exp);
         chk(err_flags === m_flags, "R7", "err_flags", err_flags, m_flags);
         chk(err_count == 16'(m_count), "R8", "err_count", err_count, m_count);
         inj = all_bad ? 8'hFF : ((k == e_beat) ? e_mask : 8'h00);
         rd_data = exp ^ inj; rd_valid = 1'b1;
         m_flags |= inj;
         m_count += $countones(inj);
         if (m_count > 65535) m_count = 65535;
         @(negedge clk);
      end
      rd_valid = 1'b0;
      chk(err_flags === m_flags, "R7", "final flags", err_flags, m_flags);
      chk(err_count == 16'(m_count), "R8", "final count", err_count, m_count);
   endtask

   task automatic end_run();
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      chk(wr_valid === 1'b0 && wr_data === 8'h00 && running === 1'b0, "R2",
          "idle after stop", {running, wr_valid, wr_data}, 0);
   endtask

   task automatic main_seq();
      for (int L = 1; L <= 32; L = L * 2) begin
         for (int j = 0; j < L; j++) sq.push_back(1'b0);
         for (int j = 0; j < L; j++) sq.push_back(1'b1);
      end
      repeat (3) @(negedge clk);
      chk({running, wr_valid, wr_data, err_flags, err_count} == '0, "R1",
          "reset state", {running, wr_valid, wr_data, err_flags, err_count}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({running, wr_valid, wr_data, err_flags, err_count} == '0, "R1",
          "after release", {running, wr_valid, wr_data}, 0);

      // R3 toggle, code 0 and code 3
      begin_run(0, 0, 0); run_beats(20, "R3", -1, 8'h00, 0); end_run();
      begin_run(3, 9, 0); run_beats(12, "R3", -1, 8'h00, 0); end_run();

      // R4 PRBS with seed, errors on lane 2 then lanes 5 and 6
      begin_run(1, 7'h35, 0); run_beats(10, "R4", 4, 8'h04, 0);
      run_beats(250, "R4", 40, 8'h60, 0);
      end_run();

      // R9 rd_valid ignored while idle
      for (int k = 0; k < 5; k++) begin
         rd_valid = 1'b1; rd_data = 8'(k * 37 + 1);
         @(negedge clk);
      end
      rd_valid = 1'b0;
      @(negedge clk);
      chk(err_flags === m_flags && err_count == 16'(m_count), "R9",
          "idle read ignored", {err_flags, err_count}, {m_flags, 16'(m_count)});

      // R4 zero seed loads as 1
      begin_run(1, 0, 0); run_beats(30, "R4", -1, 8'h00, 0); end_run();

      // R5 sweep over two full periods with a wrap, one error on lane 0
      begin_run(2, 0, 0); run_beats(260, "R5", 70, 8'h01, 0); end_run();

      // R2 start and stop together: start wins
      begin_run(2, 0, 1);
      chk(running === 1'b1, "R2", "start beats stop", running, 1);
      run_beats(8, "R5", -1, 8'h00, 0); end_run();

      // R8 saturation: every bit wrong for 8200 beats
      begin_run(1, 7'h11, 0); run_beats(8200, "R8", -1, 8'h00, 1);
      chk(err_count == 16'hFFFF, "R8", "saturated", err_count, 16'hFFFF);
      end_run();

      // R10 restart clears saturated state
      begin_run(0, 0, 0); run_beats(4, "R3", -1, 8'h00, 0); end_run();
   endtask

   initial begin
      fork
         main_seq();
         begin
            repeat (150000) @(posedge clk);
            wd_hit = 1;
         end
      join_any
      disable fork;
      if (wd_hit) begin
         total++; bad++;
         $display("FAIL watchdog actual=expired expected=done");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule